// File: doc/BRIEF.md
# Packed Rounding Q15 Multiplier

This block is a SIMD datapath stage for fixed-point signal processing. It takes two packed operands and treats each as a set of 16-bit two's-complement lanes. For each lane it multiplies the pair and returns the top half of the product, scaled and rounded as a Q15 result. The results are packed back into a word of the same width as the operands. A width select chooses a narrow operation on the low four lanes or a wide operation on all eight lanes.

The result sits in an output register. That register loads one clock after a start strobe, and a one-cycle done pulse marks the load. When a wide operation takes one operand from memory, the low address bits of that operand come in on a side input. If the address is not 16-byte aligned, the block raises a fault flag and leaves the result register unchanged.

Top module: `q15_round_mul`

## Requirements
- R1: Each lane computes the full signed 32-bit product of its two inputs. It shifts the product right arithmetically by 14, adds 1, and returns bits [16:1] of that sum.
- R2: Lane i occupies bits [16i+15:16i] of both operands and of the result. Lanes are independent of each other.
- R3: The product -32768 × -32768 gives lane result 0x8000. The value wraps and is not saturated.
- R4: With `wide` = 1, all eight lanes (bits [127:0]) are computed.
- R5: With `wide` = 0, lanes 0 to 3 are computed and result bits [127:64] are loaded as zero.
- R6: A start sampled at a clock edge loads the result register at that edge. `done` is high for exactly the following cycle.
- R7: In a cycle without start, `result` keeps its value.
- R8: A start with `wide` = 1, `mem_src` = 1 and `addr_lo` != 0 leaves `result` unchanged. It raises `align_fault` together with `done` for one cycle.
- R9: A start with `wide` = 0, or with `mem_src` = 0, never raises `align_fault`, whatever the value of `addr_lo`.
- R10: A synchronous reset clears `result`, `done` and `align_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts an operation on the current inputs |
| wide | input | 1 | 1: eight lanes (128-bit), 0: four lanes (64-bit) |
| mem_src | input | 1 | Second operand comes from memory |
| addr_lo | input | 4 | Low address bits of the memory operand |
| opa | input | 128 | First packed operand |
| opb | input | 128 | Second packed operand |
| result | output | 128 | Registered packed result |
| done | output | 1 | One-cycle pulse after each start |
| align_fault | output | 1 | One-cycle pulse marking a suppressed, misaligned wide operation |

## Verification
The assertions take for granted that `start`, `wide`, `mem_src` and `addr_lo` are steady around the clock edge at which they are sampled, and that reset is held for at least one edge. The bench drives every input at the falling edge, so each value is settled well before the rising edge that samples it. Its stimulus mixes back-to-back starts, idle gaps, and aligned and misaligned addresses in both widths. The bench checks the result register against a behavioural model on every clock. That model covers the cycles where a fault suppresses the write.

// File: rtl/q15m_pkg.sv
package q15m_pkg;
    localparam int LANE_W      = 16;
    localparam int WIDE_LANES  = 8;
    localparam int NARROW_LANES = 4;
    localparam int DATA_W      = LANE_W * WIDE_LANES;
    localparam int PROD_W      = 2 * LANE_W;
    localparam int SCALE_SHIFT = LANE_W - 2;
    localparam int ALIGN_BYTES = 16;
    localparam int ALIGN_W     = $clog2(ALIGN_BYTES);

    typedef enum logic {
        OP_NARROW = 1'b0,
        OP_WIDE   = 1'b1
    } op_width_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fault;
    } stage_t;
endpackage

// File: rtl/q15_lane.sv
module q15_lane
    import q15m_pkg::*;
(
    input  logic              en,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] y
);
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] rounded;

    always_comb begin
        prod    = $signed(a) * $signed(b);
        scaled  = prod >>> SCALE_SHIFT;
        rounded = scaled + 1;
        y       = en ? rounded[LANE_W:1] : '0;
    end
endmodule

// File: rtl/q15_align_chk.sv
module q15_align_chk
    import q15m_pkg::*;
(
    input  op_width_e          width,
    input  logic               mem_src,
    input  logic [ALIGN_W-1:0] addr_lo,
    output logic               fault
);
    always_comb begin
        fault = (width == OP_WIDE) && mem_src && (addr_lo != '0);
    end
endmodule

// File: rtl/q15_round_mul.sv
module q15_round_mul
    import q15m_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               wide,
    input  logic               mem_src,
    input  logic [ALIGN_W-1:0] addr_lo,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    output logic [DATA_W-1:0]  result,
    output logic               done,
    output logic               align_fault
);
    op_width_e width;
    stage_t    nxt;
    logic [DATA_W-1:0] lanes_out;

    assign width = wide ? OP_WIDE : OP_NARROW;

    for (genvar i = 0; i < WIDE_LANES; i++) begin : g_lane
        localparam bit ALWAYS_ON = (i < NARROW_LANES);
        logic lane_en;
        assign lane_en = ALWAYS_ON ? 1'b1 : (width == OP_WIDE);
        q15_lane u_lane (
            .en (lane_en),
            .a  (opa[i*LANE_W +: LANE_W]),
            .b  (opb[i*LANE_W +: LANE_W]),
            .y  (lanes_out[i*LANE_W +: LANE_W])
        );
    end

    q15_align_chk u_align (
        .width   (width),
        .mem_src (mem_src),
        .addr_lo (addr_lo),
        .fault   (nxt.fault)
    );

    assign nxt.data = lanes_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            result      <= '0;
            done        <= 1'b0;
            align_fault <= 1'b0;
        end else begin
            done        <= start;
            align_fault <= start && nxt.fault;
            if (start && !nxt.fault) begin
                result <= nxt.data;
            end
        end
    end

    // R6
    done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!start) |=> !done);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start) |=> $stable(result));

    // R5
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !wide) |=> (result[DATA_W-1:DATA_W/2] == '0));

    // R8
    fault_suppress_chk: assert property (@(posedge clk) disable iff (rst)
        (start && wide && mem_src && (addr_lo != '0)) |=> (align_fault && done && $stable(result)));

    // R9
    no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !(wide && mem_src)) |=> !align_fault);
endmodule

// File: tb/test_q15_round_mul.sv
module test_q15_round_mul;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic         wide;
    logic         mem_src;
    logic [3:0]   addr_lo;
    logic [127:0] opa;
    logic [127:0] opb;
    logic [127:0] result;
    logic         done;
    logic         align_fault;

    int checks = 0;
    int errors = 0;

    logic [127:0] exp_result;
    logic         exp_done;
    logic         exp_fault;
    string        exp_tag;
    bit           model_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    q15_round_mul i_q15_round_mul (
        .clk(clk), .rst(rst), .start(start), .wide(wide), .mem_src(mem_src),
        .addr_lo(addr_lo), .opa(opa), .opb(opb), .result(result),
        .done(done), .align_fault(align_fault)
    );

    function automatic logic [15:0] ref_lane(logic [15:0] a, logic [15:0] b);
        longint p;
        longint t;
        p = longint'($signed(a)) * longint'($signed(b));
        t = (p >>> 14) + 1;
        return t[16:1];
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            exp_result = '0;
            exp_done   = 1'b0;
            exp_fault  = 1'b0;
            exp_tag    = "R10";
        end else begin
            exp_done  = start;
            exp_fault = start && wide && mem_src && (addr_lo != 0);
            if (start && !exp_fault) begin
                for (int i = 0; i < 8; i++) begin
                    if (wide || i < 4)
                        exp_result[i*16 +: 16] = ref_lane(opa[i*16 +: 16], opb[i*16 +: 16]);
                    else
                        exp_result[i*16 +: 16] = 16'h0;
                end
                exp_tag = wide ? "R1 R2 R4" : "R1 R2 R5";
            end else if (start) begin
                exp_tag = "R8";
            end else begin
                exp_tag = "R7";
            end
            if (start && !(wide && mem_src)) exp_tag = {exp_tag, " R9"};
        end
    end

    // compare at every falling edge
    always @(negedge clk) begin
        if (model_on) begin
            check({exp_tag, " result"}, result, exp_result);
            check({exp_tag, " R6 done"}, {127'b0, done}, {127'b0, exp_done});
            check({exp_tag, " fault"}, {127'b0, align_fault}, {127'b0, exp_fault});
        end
    end

    task automatic op(input bit w, input bit m, input logic [3:0] ad,
                      input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        start = 1'b1; wide = w; mem_src = m; addr_lo = ad; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [127:0] fill(logic [15:0] v);
        logic [127:0] r;
        for (int i = 0; i < 8; i++) r[i*16 +: 16] = v;
        return r;
    endfunction

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] ext [4] = '{16'h7FFF, 16'h8001, 16'h8000, 16'h0000};
        rst = 1'b1; start = 1'b0; wide = 1'b0; mem_src = 1'b0; addr_lo = '0;
        opa = '1; opb = '1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 result", result, '0);
        check("R10 done", {127'b0, done}, 128'b0);
        check("R10 fault", {127'b0, align_fault}, 128'b0);
        rst = 1'b0;
        model_on = 1;

        // R3: most negative squared wraps to 0x8000
        op(1, 0, 4'h0, fill(16'h8000), fill(16'h8000));
        check("R3 wrap", result, fill(16'h8000));

        // R5: narrow leaves top zero
        op(0, 0, 4'h0, fill(16'h4000), fill(16'h4000));
        check("R5 upper zero", {64'b0, result[127:64]}, 128'b0);

        // extremes, all pairs, both widths
        foreach (ext[i]) foreach (ext[j]) begin
            op(1, 0, 4'h0, fill(ext[i]), fill(ext[j]));
            op(0, 1, 4'h7, fill(ext[j]), fill(ext[i]));   // R9: narrow ignores address
        end

        // R8: misaligned wide memory operand
        op(1, 0, 4'h0, fill(16'h1234), fill(16'h2345));
        op(1, 1, 4'h8, fill(16'h7FFF), fill(16'h7FFF));
        check("R8 suppressed", result, fill(ref_lane(16'h1234, 16'h2345)));
        op(1, 1, 4'h0, fill(16'h7FFF), fill(16'h7FFF));   // aligned: written

        // random vectors, mixed modes and gaps
        for (int n = 0; n < 200; n++) begin
            logic [127:0] a;
            logic [127:0] b;
            for (int k = 0; k < 4; k++) begin
                a[k*32 +: 32] = $urandom;
                b[k*32 +: 32] = $urandom;
            end
            @(negedge clk);
            start   = ($urandom % 4) != 0;
            wide    = $urandom % 2;
            mem_src = $urandom % 2;
            addr_lo = ($urandom % 3 == 0) ? 4'h0 : 4'($urandom);
            opa = a; opb = b;
        end
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);

        // R10: reset mid-run clears outputs
        op(1, 0, 4'h0, fill(16'h3000), fill(16'h5000));
        rst = 1'b1;
        @(negedge clk);
        model_on = 0;
        check("R10 result after reset", result, '0);
        check("R10 done after reset", {127'b0, done}, 128'b0);
        rst = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule